// File: doc/BRIEF.md
# Two-Dimensional Frame/Element DMA Channel

This block is a single DMA channel that copies 16-bit words from a source into destination memory. Each hardware request moves one frame, which holds a programmed number of elements. The destination address has two levels. Inside a frame it steps by an element offset. From one frame to the next it steps by a frame offset. A stream of interleaved samples, one word per input, can therefore be split into separate contiguous arrays, one array per input. To do this, set the element offset to the array length in bytes and the frame offset to the word size.

The source address restarts at its base at the start of every frame and advances by a source step for each element. A step of zero reads one fixed location, and a non-zero step walks a buffer window. Counts and offsets are 13-bit fields. After the programmed number of frames the channel pulses a completion interrupt. When its reload option is set, it rearms itself from the stored control packet. If a request arrives while a frame is running, the channel remembers it and serves it as soon as that frame finishes.

The memory side is a plain master. Reads have one cycle of latency, and each element takes a read cycle followed by a write cycle.

Top module: `fe_dma_engine`

## Requirements
- R1: Each accepted request (hw_req high on a clock edge while armed and idle) moves exactly elem_cnt elements, where elem_cnt is 1 to 0x1FFF.
- R2: The element with index e (counted from 0) in frame f (counted from 0) is written to byte address dst_base + f*frame_step + e*elem_step.
- R3: The element with index e of every frame is read from src_base + e*src_step, so src_step = 0 reads a single fixed address.
- R4: After the last write of frame frame_cnt-1, done_irq is high for exactly one cycle, in the cycle that follows that write.
- R5: The frame count, element count and all three offsets are 13-bit unsigned fields, and the maximum value 0x1FFF behaves like any other value.
- R6: With auto_init = 1 the channel stays armed after completion, and the next block starts again from frame 0 at dst_base. With auto_init = 0, armed falls to 0 after completion.
- R7: A request that arrives while a frame is being transferred is held, and it starts the next frame once the current one ends. No request is lost.
- R8: A request while the channel is not armed is ignored: no read or write follows.
- R9: After reset, busy, armed, rd_en, wr_en and done_irq are all 0.
- R10: Each element is a read cycle (rd_en) followed directly by a write cycle (wr_en). The write carries the 16-bit word that memory returns for that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Stores the control packet and arms the channel; acted on only while not busy |
| cfg_src_base | input | ADDR_W | Source base byte address |
| cfg_src_step | input | CNT_W | Source step per element, in bytes |
| cfg_dst_base | input | ADDR_W | Destination base byte address |
| cfg_elem_step | input | CNT_W | Destination step per element, in bytes |
| cfg_frame_step | input | CNT_W | Destination step per frame, in bytes |
| cfg_elem_cnt | input | CNT_W | Elements per frame |
| cfg_frame_cnt | input | CNT_W | Frames per block |
| cfg_auto_init | input | 1 | Rearm automatically after completion |
| hw_req | input | 1 | Hardware request, one frame per request |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | ADDR_W | Memory read byte address |
| rd_data | input | DATA_W | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write byte address |
| wr_data | output | DATA_W | Memory write data |
| done_irq | output | 1 | Block-complete pulse |
| busy | output | 1 | A frame is in progress |
| armed | output | 1 | The channel accepts requests |

## Verification
The assertions check, on every cycle, the local handshakes:
- a read is always followed by a write, and the two strobes never overlap;
- the completion pulse is one cycle wide and never coincides with a write;
- a disarmed, idle channel stays idle;
- a request that is accepted starts a read on the next cycle.

The two-level address arithmetic, the per-frame restart of the source address, the correct total of elements, and requests being held rather than dropped can only be shown by the bench scenarios. In those scenarios every captured write is compared with the address and data computed from the formulas, including 0x1FFF offsets, an 8191-frame block, back-to-back requests and reloaded blocks.

// File: rtl/fe_dma_pkg.sv
// Shared types for the frame/element DMA channel.
package fe_dma_pkg;
    // Sequencer phase: waiting, reading one element, writing it.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } dma_phase_t;
endpackage

// File: rtl/fe_dma_seq.sv
// Frame/element sequencer. It counts elements inside a frame and frames
// inside a block, holds one pending request and handles arming and reload.
// Assumes elem_cnt and frame_cnt are non-zero and stable while armed.
module fe_dma_seq
    import fe_dma_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_ok,
    input  logic             hw_req,
    input  logic [CNT_W-1:0] elem_cnt,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic             auto_init,
    output dma_phase_t       phase,
    output logic             elem_adv,
    output logic             frame_adv,
    output logic             block_end,
    output logic             armed,
    output logic             done_irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] e_idx;
    logic [CNT_W-1:0] f_idx;
    logic             pending;
    logic             last_e;
    logic             last_f;
    logic             start;

    // Decode the frame position and the step pulses for the address unit.
    always_comb begin
        last_e    = (e_idx == elem_cnt - ONE);
        last_f    = (f_idx == frame_cnt - ONE);
        start     = (phase == PH_IDLE) && armed && !load_ok && (hw_req || pending);
        elem_adv  = (phase == PH_WRITE) && !last_e;
        frame_adv = (phase == PH_WRITE) && last_e && !last_f;
        block_end = (phase == PH_WRITE) && last_e && last_f;
    end

    // Phase, counter, pending and arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            e_idx    <= '0;
            f_idx    <= '0;
            pending  <= 1'b0;
            armed    <= 1'b0;
            done_irq <= 1'b0;
        end else begin
            done_irq <= block_end;
            case (phase)
                PH_IDLE: begin
                    if (load_ok) begin
                        armed   <= 1'b1;
                        e_idx   <= '0;
                        f_idx   <= '0;
                        pending <= 1'b0;
                    end else if (start) begin
                        phase   <= PH_READ;
                        pending <= pending & hw_req;
                    end
                end
                PH_READ: begin
                    phase <= PH_WRITE;
                    if (hw_req) pending <= 1'b1;
                end
                PH_WRITE: begin
                    if (hw_req) pending <= 1'b1;
                    if (!last_e) begin
                        e_idx <= e_idx + ONE;
                        phase <= PH_READ;
                    end else begin
                        e_idx <= '0;
                        phase <= PH_IDLE;
                        if (!last_f) begin
                            f_idx <= f_idx + ONE;
                        end else begin
                            f_idx <= '0;
                            if (!auto_init) begin
                                armed   <= 1'b0;
                                pending <= 1'b0;
                            end
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fe_dma_addr.sv
// Address generator. The destination pointer moves in two dimensions
// (element step inside a frame, frame step between frames). The source
// pointer restarts at its base on every frame. Steps are zero-extended.
module fe_dma_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              elem_adv,
    input  logic              frame_adv,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [CNT_W-1:0]  src_step,
    input  logic [CNT_W-1:0]  elem_step,
    input  logic [CNT_W-1:0]  frame_step,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam int PAD_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] frame_ptr;
    logic [ADDR_W-1:0] next_frame;

    // Start address of the following frame.
    always_comb next_frame = frame_ptr + {{PAD_W{1'b0}}, frame_step};

    // Pointer updates on reload, element advance and frame advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_ptr <= '0;
            dst_addr  <= '0;
            src_addr  <= '0;
        end else if (reload) begin
            frame_ptr <= dst_base;
            dst_addr  <= dst_base;
            src_addr  <= src_base;
        end else if (frame_adv) begin
            frame_ptr <= next_frame;
            dst_addr  <= next_frame;
            src_addr  <= src_base;
        end else if (elem_adv) begin
            dst_addr  <= dst_addr + {{PAD_W{1'b0}}, elem_step};
            src_addr  <= src_addr + {{PAD_W{1'b0}}, src_step};
        end
    end
endmodule

// File: rtl/fe_dma_engine.sv
// Single-channel frame/element DMA. It stores a control packet, moves one
// frame per hardware request through a read-then-write memory master, and
// pulses done_irq at the end of a block. Memory read latency is one cycle.
module fe_dma_engine
    import fe_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_src_base,
    input  logic [CNT_W-1:0]  cfg_src_step,
    input  logic [ADDR_W-1:0] cfg_dst_base,
    input  logic [CNT_W-1:0]  cfg_elem_step,
    input  logic [CNT_W-1:0]  cfg_frame_step,
    input  logic [CNT_W-1:0]  cfg_elem_cnt,
    input  logic [CNT_W-1:0]  cfg_frame_cnt,
    input  logic              cfg_auto_init,
    input  logic              hw_req,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done_irq,
    output logic              busy,
    output logic              armed
);
    dma_phase_t        phase;
    logic              load_ok;
    logic              elem_adv;
    logic              frame_adv;
    logic              block_end;
    logic [ADDR_W-1:0] p_src_base;
    logic [ADDR_W-1:0] p_dst_base;
    logic [CNT_W-1:0]  p_src_step;
    logic [CNT_W-1:0]  p_elem_step;
    logic [CNT_W-1:0]  p_frame_step;
    logic [CNT_W-1:0]  p_elem_cnt;
    logic [CNT_W-1:0]  p_frame_cnt;
    logic              p_auto_init;
    logic [ADDR_W-1:0] src_base_sel;
    logic [ADDR_W-1:0] dst_base_sel;

    // A packet is taken only between frames.
    always_comb load_ok = cfg_load && (phase == PH_IDLE);

    // On a load, bases come straight from the inputs; on a reload, from the packet.
    always_comb begin
        src_base_sel = load_ok ? cfg_src_base : p_src_base;
        dst_base_sel = load_ok ? cfg_dst_base : p_dst_base;
    end

    // Control packet register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_src_base   <= '0;
            p_dst_base   <= '0;
            p_src_step   <= '0;
            p_elem_step  <= '0;
            p_frame_step <= '0;
            p_elem_cnt   <= '0;
            p_frame_cnt  <= '0;
            p_auto_init  <= 1'b0;
        end else if (load_ok) begin
            p_src_base   <= cfg_src_base;
            p_dst_base   <= cfg_dst_base;
            p_src_step   <= cfg_src_step;
            p_elem_step  <= cfg_elem_step;
            p_frame_step <= cfg_frame_step;
            p_elem_cnt   <= cfg_elem_cnt;
            p_frame_cnt  <= cfg_frame_cnt;
            p_auto_init  <= cfg_auto_init;
        end
    end

    fe_dma_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_ok   (load_ok),
        .hw_req    (hw_req),
        .elem_cnt  (p_elem_cnt),
        .frame_cnt (p_frame_cnt),
        .auto_init (p_auto_init),
        .phase     (phase),
        .elem_adv  (elem_adv),
        .frame_adv (frame_adv),
        .block_end (block_end),
        .armed     (armed),
        .done_irq  (done_irq)
    );

    fe_dma_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (load_ok || block_end),
        .elem_adv   (elem_adv),
        .frame_adv  (frame_adv),
        .src_base   (src_base_sel),
        .dst_base   (dst_base_sel),
        .src_step   (p_src_step),
        .elem_step  (p_elem_step),
        .frame_step (p_frame_step),
        .src_addr   (rd_addr),
        .dst_addr   (wr_addr)
    );

    // Memory master strobes; write data is the word returned by the previous read.
    always_comb begin
        rd_en   = (phase == PH_READ);
        wr_en   = (phase == PH_WRITE);
        wr_data = rd_data;
        busy    = (phase != PH_IDLE);
    end
endmodule

// File: rtl/fe_dma_chk.sv
// Protocol checker for fe_dma_engine, attached with bind.
module fe_dma_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_load,
    input logic hw_req,
    input logic rd_en,
    input logic wr_en,
    input logic done_irq,
    input logic busy,
    input logic armed
);
    // R10
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> wr_en);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R4
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !wr_en);

    // R8
    disarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !busy) |=> !busy);

    // R1
    req_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !busy && hw_req && !cfg_load) |=> rd_en);
endmodule

bind fe_dma_engine fe_dma_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .hw_req   (hw_req),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .done_irq (done_irq),
    .busy     (busy),
    .armed    (armed)
);

// File: tb/tb_fe_dma_engine.sv
module tb_fe_dma_engine;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 13;
    localparam int DATA_W = 16;
    localparam int MAXW   = 16384;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [ADDR_W-1:0] cfg_src_base = '0;
    logic [CNT_W-1:0]  cfg_src_step = '0;
    logic [ADDR_W-1:0] cfg_dst_base = '0;
    logic [CNT_W-1:0]  cfg_elem_step = '0;
    logic [CNT_W-1:0]  cfg_frame_step = '0;
    logic [CNT_W-1:0]  cfg_elem_cnt = '0;
    logic [CNT_W-1:0]  cfg_frame_cnt = '0;
    logic              cfg_auto_init = 1'b0;
    logic              hw_req = 1'b0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data = '0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              done_irq;
    logic              busy;
    logic              armed;

    int checks = 0;
    int failures = 0;
    int nw = 0;
    int ndone = 0;
    int nw_at_done = 0;
    int nrd = 0;
    int seq_bad = 0;
    logic prev_rd = 1'b0;
    logic [ADDR_W-1:0] wa [MAXW];
    logic [DATA_W-1:0] wd [MAXW];

    always #5 clk = ~clk;

    fe_dma_engine dut (.*);

    // Source memory content, computed from the address.
    function automatic logic [DATA_W-1:0] src_word(input logic [ADDR_W-1:0] a);
        return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h3C96;
    endfunction

    // Memory model: one cycle of read latency.
    always @(posedge clk) if (rd_en) rd_data <= src_word(rd_addr);

    // Capture monitor, away from the active edge.
    always @(negedge clk) begin
        if (wr_en) begin
            if (nw < MAXW) begin
                wa[nw] = wr_addr;
                wd[nw] = wr_data;
            end
            nw++;
            if (!prev_rd) seq_bad++;
        end
        if (rd_en) nrd++;
        if (done_irq) begin
            ndone++;
            nw_at_done = nw;
        end
        prev_rd = rd_en;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    int t_src, t_ss, t_dst, t_es, t_fs, t_f, t_e;
    bit t_ai;

    task automatic load(input int src, input int ss, input int dst, input int f,
                        input int e, input int es, input int fs, input bit ai);
        t_src = src; t_ss = ss; t_dst = dst; t_f = f; t_e = e;
        t_es = es; t_fs = fs; t_ai = ai;
        @(negedge clk);
        cfg_src_base = src; cfg_src_step = CNT_W'(ss); cfg_dst_base = dst;
        cfg_frame_cnt = CNT_W'(f); cfg_elem_cnt = CNT_W'(e);
        cfg_elem_step = CNT_W'(es); cfg_frame_step = CNT_W'(fs); cfg_auto_init = ai;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // mode 0: random gaps; mode 1: back-to-back so that requests become pending.
    task automatic run_block(input int mode, input string tag);
        int issued = 0;
        int wait_c = 0;
        int bad = 0;
        longint ba = 0, be = 0;
        nw = 0; ndone = 0; nw_at_done = 0; seq_bad = 0;
        for (int f = 0; f < t_f; f++) begin
            while (issued - (nw / t_e) > 1) @(negedge clk);
            if (mode == 0) begin
                int d = $urandom_range(0, 4);
                for (int k = 0; k < d; k++) @(negedge clk);
            end
            hw_req = 1'b1;
            @(negedge clk);
            hw_req = 1'b0;
            issued++;
        end
        while (ndone == 0 && wait_c < 2 * t_e + 200) begin
            @(negedge clk);
            wait_c++;
        end
        repeat (3) @(negedge clk);
        // R1 / R7: every request moved a whole frame, none lost
        chk(nw == t_f * t_e, "R1/R7", {tag, " write count"}, nw, t_f * t_e);
        // R4: single pulse after the final write
        chk(ndone == 1, "R4", {tag, " done pulses"}, ndone, 1);
        chk(nw_at_done == t_f * t_e, "R4", {tag, " writes before done"}, nw_at_done, t_f * t_e);
        // R2 / R3 / R10: address and data of every write
        for (int k = 0; k < nw && k < MAXW; k++) begin
            logic [ADDR_W-1:0] ea, sa;
            logic [DATA_W-1:0] ed;
            int f = k / t_e;
            int e = k % t_e;
            ea = ADDR_W'(t_dst) + ADDR_W'(f) * ADDR_W'(t_fs) + ADDR_W'(e) * ADDR_W'(t_es);
            sa = ADDR_W'(t_src) + ADDR_W'(e) * ADDR_W'(t_ss);
            ed = src_word(sa);
            if ((wa[k] !== ea || wd[k] !== ed) && bad == 0) begin
                ba = (wa[k] !== ea) ? longint'(wa[k]) : longint'(wd[k]);
                be = (wa[k] !== ea) ? longint'(ea) : longint'(ed);
            end
            if (wa[k] !== ea || wd[k] !== ed) bad++;
        end
        chk(bad == 0, "R2/R3", {tag, " first bad write addr/data"}, ba, be);
        chk(seq_bad == 0, "R10", {tag, " write without preceding read"}, seq_bad, 0);
        // R6: arm state after completion
        chk(armed == t_ai, "R6", {tag, " armed after block"}, armed, t_ai);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy == 0, "R9", "busy", busy, 0);
        chk(armed == 0, "R9", "armed", armed, 0);
        chk(rd_en == 0 && wr_en == 0, "R9", "strobes", {rd_en, wr_en}, 0);
        chk(done_irq == 0, "R9", "done_irq", done_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: request before any packet is ignored
        nrd = 0; nw = 0;
        hw_req = 1'b1; @(negedge clk); hw_req = 1'b0;
        repeat (8) @(negedge clk);
        chk(nrd == 0 && nw == 0, "R8", "activity before arming", nrd + nw, 0);

        // R2: three interleaved inputs split into three arrays of five samples
        load(32'h1000, 2, 32'h8000, 5, 3, 10, 2, 0);
        run_block(0, "deinterleave");

        // R8: disarmed after a block without reload
        nrd = 0; nw = 0;
        hw_req = 1'b1; @(negedge clk); hw_req = 1'b0;
        repeat (8) @(negedge clk);
        chk(nrd == 0 && nw == 0, "R8", "activity after disarm", nrd + nw, 0);

        // R7: back-to-back requests held while a frame is running
        load(32'h2000, 4, 32'h0004_0000, 4, 4, 2, 64, 0);
        run_block(1, "pending");

        // R6: reload; two blocks without reprogramming
        load(32'h3000, 2, 32'h0005_0000, 3, 2, 6, 2, 1);
        run_block(0, "autoinit1");
        run_block(1, "autoinit2");

        // R3 / R5: fixed source with maximal offsets
        load(32'h4442, 0, 32'h0010_0000, 4, 3, 13'h1FFF, 13'h1FFF, 0);
        run_block(0, "maxoffs");

        // R5: maximal frame count
        load(32'h0600, 2, 32'h0020_0000, 13'h1FFF, 1, 4, 2, 0);
        run_block(1, "maxframes");

        // R5: maximal element count and offsets in one frame
        load(32'h0800, 13'h1FFF, 32'h0100_0000, 1, 13'h1FFF, 13'h1FFF, 13'h1FFF, 0);
        run_block(0, "maxelems");

        // Random packets
        for (int r = 0; r < 8; r++) begin
            load($urandom, $urandom_range(0, 13'h1FFF), $urandom & 32'h0FFF_FFFF,
                 $urandom_range(1, 20), $urandom_range(1, 8),
                 $urandom_range(0, 13'h1FFF), $urandom_range(0, 13'h1FFF),
                 1'($urandom_range(0, 1)));
            run_block(int'($urandom_range(0, 1)), "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule